// File: doc/BRIEF.md
# Ring Mode and Off-Hook Sample Controller

This block sits between the primary drive generator and the output drivers of a ringing supply. It decides whether the secondary sampling switch is fired by the offset-frequency strobe from the generator (ringing mode), or by a pulse of its own. That own pulse is locked to the primary phase B drive, which makes the output a DC level only (DC mode). In DC mode the pulse trails the rising edge of phase B by a programmable number of clocks, and the number of clocks sets the DC level.

The block also gates every drive output. A low enable kills all three outputs at once. A primary overcurrent flag blanks them cycle by cycle: the outputs stay off until the next phase A rising edge seen while the flag is clear. The off-hook and overcurrent comparator flags are asynchronous, and each passes through a two-flop synchronizer.

There are two state machines. The mode register has the states MODE_DC and MODE_RING. At a phase B rising edge it moves to MODE_RING if ring_en is high and the synchronized off-hook flag is low, and to MODE_DC otherwise. Between those edges it holds its state. The DC pulse sequencer has the states SP_IDLE, SP_WAIT and SP_FIRE:
- SP_IDLE to SP_FIRE: a phase B rise in DC with delay 0.
- SP_IDLE to SP_WAIT: a phase B rise in DC with a nonzero delay.
- SP_WAIT counts down to SP_FIRE. A phase B rise restarts it, or sends it to SP_IDLE if ringing is now wanted.
- SP_FIRE always returns to SP_IDLE.

Top module: `ring_mode_sampler`

## Requirements
- R1: mode_dc is low (ringing mode) only when, at the most recent phase B rising edge, ring_en was high and the synchronized off-hook flag was low. In ringing mode, a one-clock ring_strobe pulse appears on drv_s one clock later.
- R2: In DC mode (mode_dc high), ring_strobe has no effect on drv_s. Exactly one drv_s pulse is issued per phase B rising edge.
- R3: In DC mode, the drv_s pulse is high d clocks after the first clock in which drv_b is high. d is delay_code for codes 0 to 4, and 4 for codes 5, 6 and 7.
- R4: Every drv_s pulse is exactly one clock wide, in both modes.
- R5: A change of ring_en or of the off-hook flag alters mode_dc and the source of drv_s only at the next rising edge of pri_b_in.
- R6: While enable is low, drv_a, drv_b and drv_s are all low.
- R7: ilim_raw is taken through two synchronizer flops. From the third clock edge after ilim_raw goes high, all three drives are low. They stay low until a rising edge of pri_a_in arrives while the synchronized flag is clear; drv_a is high in the clock that follows that edge.
- R8: When not blanked, drv_a and drv_b follow pri_a_in and pri_b_in with one clock of latency.
- R9: After reset the block is in DC mode (mode_dc high) with all drives low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one delay step |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | High allows the drives to toggle |
| ring_en | input | 1 | Request for ringing |
| offhook_raw | input | 1 | Asynchronous off-hook comparator flag |
| ilim_raw | input | 1 | Asynchronous primary overcurrent flag |
| delay_code | input | 3 | DC-mode sample delay in clocks, clamped to 4 |
| pri_a_in | input | 1 | Primary phase A drive from the generator |
| pri_b_in | input | 1 | Primary phase B drive from the generator |
| ring_strobe | input | 1 | Ringing-mode sample strobe from the generator |
| drv_a | output | 1 | Gated phase A drive |
| drv_b | output | 1 | Gated phase B drive |
| drv_s | output | 1 | Gated sampling-switch pulse |
| mode_dc | output | 1 | High in DC mode, low in ringing mode |

## Verification
The hardest case to reach is a mode request that changes in the middle of a primary period. It has to be shown that nothing moves until the next phase B edge. The stimulus holds the primary idle after a period and then flips ring_en or the off-hook flag. It fires strobes while the old mode is still latched, and those strobes must pass or vanish according to the old mode. A second hard case is an overcurrent pulse timed on a phase B rise with a nonzero delay: the DC pulse already scheduled must be swallowed by the blanking, and the drives must come back on exactly at the following phase A rise.

// File: rtl/ring_pkg.sv
package ring_pkg;

    typedef enum logic {
        MODE_DC   = 1'b0,
        MODE_RING = 1'b1
    } mode_e;

    typedef enum logic [1:0] {
        SP_IDLE = 2'd0,
        SP_WAIT = 2'd1,
        SP_FIRE = 2'd2
    } spulse_e;

endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q = chain_q[LAST];

    initial begin
        assert (STAGES >= 2) else $error("flag_sync needs at least two stages");
    end
endmodule

// File: rtl/mode_select.sv
module mode_select
    import ring_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  edge_b,
    input  logic  ring_en,
    input  logic  offhook,
    output logic  want_dc,
    output mode_e mode
);
    mode_e mode_q, mode_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_DC;
        else        mode_q <= mode_n;
    end

    // next state and outputs
    always_comb begin
        want_dc = !(ring_en && !offhook);
        mode_n  = mode_q;
        unique case (mode_q)
            MODE_DC:   if (edge_b && !want_dc) mode_n = MODE_RING;
            MODE_RING: if (edge_b &&  want_dc) mode_n = MODE_DC;
            default:   mode_n = MODE_DC;
        endcase
        mode = mode_q;
    end

    AST_MODE_ONLY_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != $past(mode_q)) |-> $past(edge_b)); // R5
endmodule

// File: rtl/dc_sample_gen.sv
module dc_sample_gen
    import ring_pkg::*;
#(
    parameter int DLY_W   = 3,
    parameter int DLY_MAX = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_b,
    input  logic             want_dc,
    input  logic [DLY_W-1:0] delay_code,
    output logic             fire
);
    localparam int CNT_W = $clog2(DLY_MAX + 1);

    spulse_e          st_q, st_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [CNT_W-1:0] eff;

    assign eff = (delay_code > DLY_W'(DLY_MAX)) ? CNT_W'(DLY_MAX) : CNT_W'(delay_code);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= SP_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    // transitions
    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        unique case (st_q)
            SP_IDLE: begin
                if (edge_b && want_dc) begin
                    if (eff == '0) begin
                        st_n = SP_FIRE;
                    end else begin
                        st_n  = SP_WAIT;
                        cnt_n = eff;
                    end
                end
            end
            SP_WAIT: begin
                if (edge_b) begin
                    if (!want_dc) begin
                        st_n = SP_IDLE;
                    end else if (eff == '0) begin
                        st_n = SP_FIRE;
                    end else begin
                        cnt_n = eff;
                    end
                end else if (cnt_q == CNT_W'(1)) begin
                    st_n = SP_FIRE;
                end else begin
                    cnt_n = cnt_q - CNT_W'(1);
                end
            end
            SP_FIRE: st_n = SP_IDLE;
            default: st_n = SP_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        fire = (st_q == SP_FIRE);
    end

    AST_FIRE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire); // R4
    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SP_WAIT) |-> (cnt_q != '0) && (cnt_q <= CNT_W'(DLY_MAX))); // R3
endmodule

// File: rtl/ring_mode_sampler.sv
module ring_mode_sampler
    import ring_pkg::*;
#(
    parameter int DLY_W       = 3,
    parameter int DLY_MAX     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             ring_en,
    input  logic             offhook_raw,
    input  logic             ilim_raw,
    input  logic [DLY_W-1:0] delay_code,
    input  logic             pri_a_in,
    input  logic             pri_b_in,
    input  logic             ring_strobe,
    output logic             drv_a,
    output logic             drv_b,
    output logic             drv_s,
    output logic             mode_dc
);
    localparam int NFLAG = 2;

    logic [NFLAG-1:0] flags_s;
    logic             offhook_s, ilim_s;
    logic             pri_a_q, pri_b_q, strobe_q, blank_q;
    logic             edge_a, edge_b;
    logic             want_dc, fire, gate;
    mode_e            mode;

    flag_sync #(.W(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ilim_raw, offhook_raw}),
        .q     (flags_s)
    );
    assign offhook_s = flags_s[0];
    assign ilim_s    = flags_s[1];

    assign edge_a = pri_a_in && !pri_a_q;
    assign edge_b = pri_b_in && !pri_b_q;

    mode_select u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .edge_b  (edge_b),
        .ring_en (ring_en),
        .offhook (offhook_s),
        .want_dc (want_dc),
        .mode    (mode)
    );

    dc_sample_gen #(.DLY_W(DLY_W), .DLY_MAX(DLY_MAX)) u_dcgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_b     (edge_b),
        .want_dc    (want_dc),
        .delay_code (delay_code),
        .fire       (fire)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pri_a_q  <= 1'b0;
            pri_b_q  <= 1'b0;
            strobe_q <= 1'b0;
            blank_q  <= 1'b0;
        end else begin
            pri_a_q  <= pri_a_in;
            pri_b_q  <= pri_b_in;
            strobe_q <= ring_strobe;
            if (ilim_s)      blank_q <= 1'b1;
            else if (edge_a) blank_q <= 1'b0;
        end
    end

    always_comb begin
        gate    = enable && !blank_q;
        drv_a   = gate && pri_a_q;
        drv_b   = gate && pri_b_q;
        drv_s   = gate && (((mode == MODE_RING) && strobe_q) || fire);
        mode_dc = (mode == MODE_DC);
    end

    AST_FIRE_IN_DC: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (mode == MODE_DC)); // R2
    AST_ILIM_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ilim_s) |-> (!drv_a && !drv_b && !drv_s)); // R7
    AST_RING_STROBE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ring_strobe) && (mode == MODE_DC) && !fire) |-> !drv_s); // R2
endmodule

// File: tb/ring_mode_sampler_test.sv
`timescale 1ns/1ps
module ring_mode_sampler_test;
    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0, ring_en = 1'b0, offhook_raw = 1'b0, ilim_raw = 1'b0;
    logic [2:0] delay_code = 3'd0;
    logic       pri_a_in = 1'b0, pri_b_in = 1'b0, ring_strobe = 1'b0;
    logic       drv_a, drv_b, drv_s, mode_dc;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;
    int expq[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ring_mode_sampler uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .ring_en(ring_en),
        .offhook_raw(offhook_raw), .ilim_raw(ilim_raw), .delay_code(delay_code),
        .pri_a_in(pri_a_in), .pri_b_in(pri_b_in), .ring_strobe(ring_strobe),
        .drv_a(drv_a), .drv_b(drv_b), .drv_s(drv_s), .mode_dc(mode_dc)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // monitor: every drv_s pulse must match the next expected cycle (R2 R3 R4)
    always begin
        @(negedge clk);
        #1;
        if (rst_n && drv_s) begin
            if (expq.size() == 0) begin
                check(0, "R2/R4 unexpected drv_s pulse", cyc, -1);
            end else begin
                int e;
                e = expq.pop_front();
                check(cyc == e, "R3/R4 drv_s pulse cycle", cyc, e);
            end
        end
    end

    // one primary period; optionally expect a DC pulse and check mode/drives
    task automatic period(input bit push_dc, input int eff, input int exp_mode, input bit chk);
        int m;
        @(negedge clk);
        m = cyc;
        pri_b_in = 1'b1;
        pri_a_in = 1'b0;
        if (push_dc) expq.push_back(m + 1 + eff);
        for (int i = 0; i < H; i++) begin
            @(negedge clk);
            if (i == 0 && chk) check(drv_b == 1'b1, "R8 drv_b follows pri_b", drv_b, 1);
            if (i == 0 && exp_mode >= 0) check(mode_dc == exp_mode[0], "R1/R2/R5 mode after edge", mode_dc, exp_mode);
        end
        pri_b_in = 1'b0;
        pri_a_in = 1'b1;
        for (int i = 0; i < H; i++) begin
            @(negedge clk);
            if (i == 0 && chk) check(drv_a == 1'b1, "R8 drv_a follows pri_a", drv_a, 1);
        end
    endtask

    task automatic strobe(input bit expect_pulse);
        @(negedge clk);
        ring_strobe = 1'b1;
        if (expect_pulse) expq.push_back(cyc + 1);
        @(negedge clk);
        ring_strobe = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int m;
        repeat (3) @(negedge clk);
        // R9 reset state
        check(mode_dc == 1'b1, "R9 reset mode", mode_dc, 1);
        check({drv_a, drv_b, drv_s} == 3'b000, "R9 reset drives", {drv_a, drv_b, drv_s}, 0);
        rst_n = 1'b1;
        enable = 1'b1;
        repeat (4) @(negedge clk);

        // R3 delay sweep in DC mode, codes 5..7 clamp to 4
        for (int c = 0; c < 8; c++) begin
            delay_code = 3'(c);
            period(1, (c > 4) ? 4 : c, 1, c == 0);
        end

        // R5 ring request mid-period: strobe ignored until next pri_b rise (R2)
        delay_code = 3'd2;
        ring_en = 1'b1;
        strobe(0);
        check(mode_dc == 1'b1, "R5 mode holds before edge", mode_dc, 1);
        period(0, 0, 0, 0);                       // R1 ringing entered
        strobe(1);                                // R1 R4
        strobe(1);

        // R5 off-hook flag while ringing: mode holds until edge
        offhook_raw = 1'b1;
        repeat (4) @(negedge clk);
        check(mode_dc == 1'b0, "R5 ringing holds after off-hook", mode_dc, 0);
        strobe(1);
        period(1, 2, 1, 0);                       // R2 DC entered
        strobe(0);                                // R2 strobe ignored in DC

        // cadence: toggle ring_en with off-hook clear (R1 R2)
        offhook_raw = 1'b0;
        repeat (4) @(negedge clk);
        period(0, 0, 0, 0);
        strobe(1);
        ring_en = 1'b0;
        period(1, 2, 1, 0);
        ring_en = 1'b1;
        period(0, 0, 0, 0);
        ring_en = 1'b0;
        period(1, 2, 1, 0);

        // R6 enable low
        enable = 1'b0;
        @(negedge clk);
        m = cyc;
        pri_b_in = 1'b1; pri_a_in = 1'b0;
        @(negedge clk);
        check(drv_b == 1'b0, "R6 drv_b off while disabled", drv_b, 0);
        repeat (3) @(negedge clk);
        check(drv_s == 1'b0, "R6 drv_s off while disabled", drv_s, 0);
        repeat (H - 4) @(negedge clk);
        pri_b_in = 1'b0; pri_a_in = 1'b1;
        @(negedge clk);
        check(drv_a == 1'b0, "R6 drv_a off while disabled", drv_a, 0);
        repeat (H) @(negedge clk);
        enable = 1'b1;
        period(1, 2, 1, 1);

        // R7 current limit on a pri_b rise with delay 2: pulse swallowed
        @(negedge clk);
        m = cyc;
        pri_b_in = 1'b1; pri_a_in = 1'b0; ilim_raw = 1'b1;
        @(negedge clk);
        ilim_raw = 1'b0;
        @(negedge clk);
        check(drv_b == 1'b1, "R7 drives live before third edge", drv_b, 1);
        @(negedge clk);
        check(drv_b == 1'b0, "R7 drv_b blanked", drv_b, 0);
        repeat (H - 3) @(negedge clk);
        check(drv_b == 1'b0, "R7 blank held to pri_a rise", drv_b, 0);
        pri_b_in = 1'b0; pri_a_in = 1'b1;
        @(negedge clk);
        check(drv_a == 1'b1, "R7 drv_a resumes at pri_a rise", drv_a, 1);
        repeat (H - 1) @(negedge clk);
        period(1, 2, 1, 1);

        repeat (6) @(negedge clk);
        check(expq.size() == 0, "R2 all expected pulses seen", expq.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule